// File: doc/BRIEF.md
# RV32 Jump Target and Link Unit

This block serves the unconditional-jump path of a 32-bit RISC-V integer core. Each clock it takes the address of the current instruction, the 32-bit instruction word and the value read from the rs1 register. It decides whether the word is a jump-and-link or a register-indirect jump-and-link. It rebuilds the matching immediate and sign-extends it, then forms the jump target. It also forms the return address that the core writes into rd, and it raises a flag when the target is not on a 4-byte boundary.

The jump-and-link immediate is stored in the instruction in a shuffled bit order. The unit puts it back into a 21-bit signed offset whose bit 0 is always zero. For the register-indirect form it adds the 12-bit immediate to rs1 and then forces bit 0 of the sum to zero. All results go through one register stage. Each output therefore shows the instruction that was presented at the previous rising clock edge.

Top module: `rvj_jump_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are zero after that edge.
- R2: An instruction whose opcode bits [6:0] are 7'b1101111 raises `jump_o`, and the target is `pc_i` plus the J-type immediate.
- R3: Opcode 7'b1100111 raises `jump_o` only when funct3 (bits [14:12]) is 3'b000. Every other encoding leaves `jump_o` low and drives `target_o`, `link_o` and `misalign_o` to zero.
- R4: The J-type immediate places instruction bit 31 at offset bit 20, bits [30:21] at offset bits [10:1], bit 20 at offset bit 11 and bits [19:12] at offset bits [19:12]. Offset bit 0 is zero, and the offset is sign-extended to the full width.
- R5: The register-indirect target is `rs1_i` plus the sign-extended value of instruction bits [31:20], with bit 0 of the sum forced to zero.
- R6: For both jump forms, `link_o` equals `pc_i` plus 4, wrapping at the word width.
- R7: `misalign_o` is high exactly when `jump_o` is high and bit 1 of `target_o` is set.
- R8: Outputs change only at rising edges, and they reflect the inputs sampled at the previous rising edge.
- R9: The jump-and-link word 32'h0000006F (offset zero) produces a target equal to its own `pc_i`.
- R10: The extreme J-type offsets +1048574 (word 32'h7FFFF06F) and -1048576 (word 32'h8000006F) produce `pc_i` plus that offset, wrapping at the word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | XLEN | Address of the instruction presented |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | XLEN | Value of the rs1 register |
| jump_o | output | 1 | Registered: the instruction was a recognised jump |
| target_o | output | XLEN | Registered jump target address |
| link_o | output | XLEN | Registered return address for rd |
| misalign_o | output | 1 | Registered: the target is not 4-byte aligned |

## Verification
The bench builds the unit with XLEN at its default of 32. At that width the sign extension of both immediates runs up to the top bit, and program-counter and rs1 values near either end of the address space make the target and link sums wrap past bit 31. The random stimulus mixes both jump encodings, register-indirect opcodes with a wrong funct3, and arbitrary words. The directed cases cover the zero-offset self jump and the two extreme J-type offsets. Odd rs1 sums check that bit 0 is cleared.

// File: rtl/rvj_pkg.sv
package rvj_pkg;
  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_JALR = 7'b1100111;
  localparam logic [2:0] F3_JALR  = 3'b000;
  localparam int unsigned INSN_W  = 32;

  typedef enum logic [1:0] {
    JK_NONE = 2'd0,
    JK_JAL  = 2'd1,
    JK_JALR = 2'd2
  } jkind_t;
endpackage

// File: rtl/rvj_decode.sv
module rvj_decode
  import rvj_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output jkind_t            kind
);
  logic [6:0] opc;
  logic [2:0] f3;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];

  always_comb begin
    kind = JK_NONE;
    if (opc == OPC_JAL)
      kind = JK_JAL;
    else if (opc == OPC_JALR && f3 == F3_JALR)
      kind = JK_JALR;
  end
endmodule

// File: rtl/rvj_imm.sv
module rvj_imm
  import rvj_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSN_W-1:0] instr,
  input  jkind_t            kind,
  output logic [XLEN-1:0]   imm
);
  localparam int unsigned JBITS = 21;
  localparam int unsigned IBITS = 12;
  localparam int unsigned JEXT  = XLEN - JBITS;
  localparam int unsigned IEXT  = XLEN - IBITS;

  logic [JBITS-1:0] j_raw;
  logic [IBITS-1:0] i_raw;
  logic [XLEN-1:0]  j_ext;
  logic [XLEN-1:0]  i_ext;

  // Reassemble the shuffled jump offset; bit 0 is implicit zero.
  assign j_raw = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
  assign i_raw = instr[31:20];

  assign j_ext = {{JEXT{j_raw[JBITS-1]}}, j_raw};
  assign i_ext = {{IEXT{i_raw[IBITS-1]}}, i_raw};

  always_comb begin
    unique case (kind)
      JK_JAL:  imm = j_ext;
      JK_JALR: imm = i_ext;
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/rvj_target.sv
module rvj_target
  import rvj_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  jkind_t          kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] link
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;

  assign base = (kind == JK_JALR) ? rs1 : pc;
  assign sum  = base + imm;
  // Register-indirect form drops bit 0 of the sum.
  assign target = {sum[XLEN-1:1], (kind == JK_JALR) ? 1'b0 : sum[0]};
  assign link   = pc + STEP;
endmodule

// File: rtl/rvj_jump_unit.sv
module rvj_jump_unit
  import rvj_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  output logic            jump_o,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o,
  output logic            misalign_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  jkind_t          kind_d, kind_q;
  logic [XLEN-1:0] imm_d, tgt_d, lnk_d;
  logic            hit_d;

  rvj_decode u_dec (
    .instr (instr_i),
    .kind  (kind_d)
  );

  rvj_imm #(.XLEN(XLEN)) u_imm (
    .instr (instr_i),
    .kind  (kind_d),
    .imm   (imm_d)
  );

  rvj_target #(.XLEN(XLEN)) u_tgt (
    .kind   (kind_d),
    .pc     (pc_i),
    .rs1    (rs1_i),
    .imm    (imm_d),
    .target (tgt_d),
    .link   (lnk_d)
  );

  assign hit_d = (kind_d != JK_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q     <= JK_NONE;
      jump_o     <= 1'b0;
      target_o   <= '0;
      link_o     <= '0;
      misalign_o <= 1'b0;
    end else begin
      kind_q     <= kind_d;
      jump_o     <= hit_d;
      target_o   <= hit_d ? tgt_d : '0;
      link_o     <= hit_d ? lnk_d : '0;
      misalign_o <= hit_d & tgt_d[1];
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!jump_o && target_o == '0 && link_o == '0 && !misalign_o));

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !jump_o |-> (target_o == '0 && link_o == '0 && !misalign_o));

  p_jal_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (jump_o && kind_q == JK_JAL) |-> (target_o[0] == $past(pc_i[0])));

  p_jalr_lsb_r5: assert property (@(posedge clk) disable iff (rst)
    (jump_o && kind_q == JK_JALR) |-> !target_o[0]);

  p_link_r6: assert property (@(posedge clk) disable iff (rst)
    jump_o |-> (link_o == $past(pc_i) + STEP));

  p_misalign_r7: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> (jump_o && target_o[1]));
endmodule

// File: tb/test_rvj_jump_unit.sv
module test_rvj_jump_unit;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [XLEN-1:0] pc_i = '0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] rs1_i = '0;
  logic            jump_o, misalign_o;
  logic [XLEN-1:0] target_o, link_o;

  int total = 0;
  int bad   = 0;

  logic            e_v, e_m;
  logic [XLEN-1:0] e_t, e_l;

  always #10 clk = ~clk;

  rvj_jump_unit #(.XLEN(XLEN)) i_rvj_jump_unit (
    .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i), .rs1_i(rs1_i),
    .jump_o(jump_o), .target_o(target_o), .link_o(link_o), .misalign_o(misalign_o)
  );

  task automatic check(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference from the requirements.
  task automatic model(input logic [31:0] pc, input logic [31:0] ins, input logic [31:0] r1);
    logic signed [31:0] off;
    logic [31:0] t;
    e_v = 1'b0; e_t = '0; e_l = '0; e_m = 1'b0;
    if (ins[6:0] == 7'b1101111) begin
      off = 0;
      off[20] = ins[31];
      for (int k = 1; k <= 10; k++) off[k] = ins[20 + k];
      off[11] = ins[20];
      for (int k = 12; k <= 19; k++) off[k] = ins[k];
      for (int k = 21; k <= 31; k++) off[k] = ins[31];
      t = pc + off;
      e_v = 1'b1;
    end else if (ins[6:0] == 7'b1100111 && ins[14:12] == 3'b000) begin
      off = 32'(signed'(ins[31:20]));
      t = r1 + off;
      t = t & 32'hFFFF_FFFE;
      e_v = 1'b1;
    end
    if (e_v) begin
      e_t = t;
      e_l = pc + 32'd4;
      e_m = t[1];
    end
  endtask

  // Drive at the falling edge; the next falling edge sees the result.
  task automatic apply(input string req, input logic [31:0] pc,
                       input logic [31:0] ins, input logic [31:0] r1);
    logic [XLEN-1:0] old_t;
    old_t = target_o;
    pc_i = pc; instr_i = ins; rs1_i = r1;
    model(pc, ins, r1);
    #1 check("R8", "hold before edge", target_o, old_t);
    @(negedge clk);
    check(e_v ? "R2" : "R3", "jump_o", {31'd0, jump_o}, {31'd0, e_v});
    check(e_v ? req : "R3", "target_o", target_o, e_t);
    check(e_v ? "R6" : "R3", "link_o", link_o, e_l);
    check("R7", "misalign_o", {31'd0, misalign_o}, {31'd0, e_m});
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    rst = 1'b1;
    pc_i = 32'h100; instr_i = 32'h0000006F;
    @(negedge clk); @(negedge clk);
    check("R1", "jump_o in reset", {31'd0, jump_o}, 32'd0);
    check("R1", "target_o in reset", target_o, '0);
    check("R1", "link_o in reset", link_o, '0);
    rst = 1'b0;

    apply("R9", 32'h0000_0010, 32'h0000_006F, 32'h0);
    apply("R9", 32'h8000_12F4, 32'h0000_006F, 32'h0);
    apply("R10", 32'h0000_1000, 32'h7FFF_F06F, 32'h0);
    apply("R10", 32'h0000_1000, 32'h8000_006F, 32'h0);
    apply("R10", 32'hFFFF_FFF0, 32'h7FFF_F06F, 32'h0);
    apply("R4", 32'h0000_2000, 32'h0010_006F, 32'h0);
    apply("R4", 32'h0000_2000, 32'h0000_106F, 32'h0);
    apply("R5", 32'h0000_0040, 32'h0010_0067, 32'h0000_0101);
    apply("R5", 32'h0000_0040, 32'hFFF0_0067, 32'h0000_0000);
    apply("R5", 32'h0000_0040, 32'h0020_0067, 32'h0000_0000);
    apply("R3", 32'h0000_0040, 32'h0000_1067, 32'h0000_0010);
    apply("R3", 32'h0000_0040, 32'h0000_0063, 32'h0000_0010);
    apply("R6", 32'hFFFF_FFFC, 32'h0080_006F, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      w = $urandom;
      case ($urandom % 4)
        0: w[6:0] = 7'b1101111;
        1: begin w[6:0] = 7'b1100111; w[14:12] = 3'b000; end
        2: w[6:0] = 7'b1100111;
        default: ;
      endcase
      apply(w[6:0] == 7'b1100111 ? "R5" : "R2", $urandom, w, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule